// File: doc/BRIEF.md
# Receive byte ordering aligner

This block sits behind a receive byte deserializer that hands over words of several bytes each (two by default). The byte in the least significant lane of a word is the earliest byte in stream order. After it has been armed, the aligner looks for a configured ordering byte in the incoming words. If that byte shows up in an upper lane, the aligner inserts pad bytes so that the ordering byte moves into the least significant lane of the next output word. All later bytes stay shifted by the same amount, and the earlier ones are carried over between words so that no byte is lost. It then raises an alignment flag.

Arming is selected by a static mode input. In automatic mode a rising edge of the link's sync-status input arms a new search. In manual mode a rising edge of a separate ordering-enable input does it. The other input is ignored. After a match the aligner keeps its shift and its flag, and later ordering bytes in any lane have no effect, until the selected input rises again. That new edge drops the stored shift and the flag, and the search begins with the word of that same cycle. Input and output are a plain word stream with one word per clock and one cycle of latency.

Top module: `byte_order_aligner`

## Requirements
- R1: After reset, `ord_aligned` is 0 and `ord_word` is 0. Until the first rising edge of the selected trigger, input words pass through unshifted with one cycle of latency and `ord_aligned` stays 0, even when they hold the pattern. The edge detector's history resets to 0, so a trigger that is high in the first cycle after reset counts as a rising edge.
- R2: With `cfg_manual` = 0, a rising edge of `sync_status` arms a search, and `ord_enable` has no effect.
- R3: With `cfg_manual` = 1, a rising edge of `ord_enable` arms a search, and `sync_status` has no effect.
- R4: If the pattern is found in lane 0 (bits [BW-1:0]) of a searched word, that word is output unchanged one cycle later and `ord_aligned` rises in the same cycle.
- R5: If the pattern is first found in lane m > 0, the output word for that input keeps input lanes 0..m-1, and lanes m..NB-1 carry `cfg_pad`, with `ord_aligned` still 0. On the next output word the pattern sits in lane 0 and `ord_aligned` is 1.
- R6: After a lane-m match the stored shift is s = NB-m. Every later output word holds, in lanes 0..s-1, the previous input word's lanes m..NB-1, and in lanes s..NB-1, the current input word's lanes 0..m-1. No byte is dropped or repeated.
- R7: When several lanes of a searched word hold the pattern, the lowest lane is the one used.
- R8: While aligned, pattern bytes in any lane and falling or steady trigger levels change neither the shift nor `ord_aligned`.
- R9: A rising trigger edge clears `ord_aligned` and the shift for the output word of that same cycle. Carried bytes are dropped. The input word of that cycle is already searched, and an edge in the pad cycle of R5 takes priority over the pending flag.
- R10: While a search is armed and nothing has matched yet, words pass through unshifted and `ord_aligned` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_manual | input | 1 | Static mode: 0 arms on `sync_status`, 1 arms on `ord_enable` |
| cfg_pattern | input | BW | Ordering byte to search for |
| cfg_pad | input | BW | Byte value inserted as padding |
| sync_status | input | 1 | Link synchronisation status (trigger in automatic mode) |
| ord_enable | input | 1 | Ordering enable (trigger in manual mode) |
| in_word | input | NB*BW | Deserialized word, lane 0 = earliest byte |
| ord_word | output | NB*BW | Ordered word, one cycle after input |
| ord_aligned | output | 1 | Ordering pattern is in lane 0 and the shift is fixed |

## Verification
Two functions can fall in the same cycle: re-arming on a trigger edge, and acting on a match or a pending pad step. The bench raises the trigger in the same cycle as a word that holds the pattern, in lane 0 and in lane 1, and expects clear and match to combine, so that the new flag or new pad shows at once. It also raises the trigger in the pad cycle that follows an upper-lane match, where the edge must win: the output stays unshifted with the flag low. It judges each case from the output word and flag one cycle later.

// File: rtl/bo_pkg.sv
package bo_pkg;

    typedef enum logic {
        ARM_ON_SYNC   = 1'b0,
        ARM_ON_ENABLE = 1'b1
    } arm_mode_e;

endpackage

// File: rtl/bo_trigger_edge.sv
module bo_trigger_edge
    import bo_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  arm_mode_e mode,
    input  logic      sync_status,
    input  logic      ord_enable,
    output logic      rise
);
    logic sel;
    logic last_d, last_q;

    // pick the trigger named by the mode; the other input is never looked at
    always_comb begin
        sel    = (mode == ARM_ON_ENABLE) ? ord_enable : sync_status;
        last_d = sel;
        rise   = sel & ~last_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= last_d;
    end

    // two edges cannot follow back to back (R2, R3)
    assert_no_double_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/bo_lane_finder.sv
module bo_lane_finder #(
    parameter int NB    = 2,
    parameter int BW    = 8,
    parameter int IDX_W = $clog2(NB)
) (
    input  logic [NB*BW-1:0] word,
    input  logic [BW-1:0]    pattern,
    input  logic             search,
    output logic [NB-1:0]    grant,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    logic [NB-1:0] eq;

    // per-lane compare and lowest-lane priority mask
    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign eq[g] = search && (word[g*BW +: BW] == pattern);
        if (g == 0) begin : g_first
            assign grant[g] = eq[g];
        end else begin : g_rest
            assign grant[g] = eq[g] & ~(|eq[g-1:0]);
        end
    end

    always_comb begin
        hit = |grant;
        idx = '0;
        for (int i = 0; i < NB; i++) begin
            if (grant[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/bo_lane_shift.sv
module bo_lane_shift #(
    parameter int NB    = 2,
    parameter int BW    = 8,
    parameter int IDX_W = $clog2(NB)
) (
    input  logic [NB*BW-1:0] cur_word,
    input  logic [NB*BW-1:0] prev_word,
    input  logic [IDX_W-1:0] shift,
    input  logic             pad_on,
    input  logic [IDX_W-1:0] pad_from,
    input  logic [BW-1:0]    pad_byte,
    output logic [NB*BW-1:0] out_word
);
    for (genvar k = 0; k < NB; k++) begin : g_out
        always_comb begin
            if (pad_on && (k >= int'(pad_from))) begin
                out_word[k*BW +: BW] = pad_byte;
            end else if (k < int'(shift)) begin
                out_word[k*BW +: BW] = prev_word[(NB - int'(shift) + k)*BW +: BW];
            end else begin
                out_word[k*BW +: BW] = cur_word[(k - int'(shift))*BW +: BW];
            end
        end
    end

endmodule

// File: rtl/byte_order_aligner.sv
module byte_order_aligner
    import bo_pkg::*;
#(
    parameter int NB = 2,
    parameter int BW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_manual,
    input  logic [BW-1:0]    cfg_pattern,
    input  logic [BW-1:0]    cfg_pad,
    input  logic             sync_status,
    input  logic             ord_enable,
    input  logic [NB*BW-1:0] in_word,
    output logic [NB*BW-1:0] ord_word,
    output logic             ord_aligned
);
    localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1;
    localparam int WW    = NB * BW;

    typedef struct packed {
        logic             armed;
        logic             pend;
        logic             aligned;
        logic [IDX_W-1:0] shift;
        logic [WW-1:0]    prev;
        logic [WW-1:0]    out;
    } state_t;

    state_t s_d, s_q;

    logic             rise;
    logic             search;
    logic [NB-1:0]    grant;
    logic             hit;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] eff_shift;
    logic             pad_on;
    logic [WW-1:0]    shaped;

    bo_trigger_edge i_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (arm_mode_e'(cfg_manual)),
        .sync_status (sync_status),
        .ord_enable  (ord_enable),
        .rise        (rise)
    );

    bo_lane_finder #(.NB(NB), .BW(BW), .IDX_W(IDX_W)) i_find (
        .word    (in_word),
        .pattern (cfg_pattern),
        .search  (search),
        .grant   (grant),
        .hit     (hit),
        .idx     (idx)
    );

    bo_lane_shift #(.NB(NB), .BW(BW), .IDX_W(IDX_W)) i_shift (
        .cur_word  (in_word),
        .prev_word (s_q.prev),
        .shift     (eff_shift),
        .pad_on    (pad_on),
        .pad_from  (idx),
        .pad_byte  (cfg_pad),
        .out_word  (shaped)
    );

    always_comb begin
        search    = s_q.armed | rise;
        eff_shift = rise ? '0 : s_q.shift;
        pad_on    = hit && (idx != '0);

        s_d       = s_q;
        s_d.prev  = in_word;
        s_d.pend  = 1'b0;

        // a new edge wipes the old order and arms a search on this word
        if (rise) begin
            s_d.armed   = 1'b1;
            s_d.aligned = 1'b0;
            s_d.shift   = '0;
        end

        if (hit) begin
            s_d.armed = 1'b0;
            if (idx == '0) begin
                s_d.aligned = 1'b1;
            end else begin
                s_d.shift = IDX_W'(NB - int'(idx));
                s_d.pend  = 1'b1;
            end
        end

        // pattern lands in lane 0 one word after the pads
        if (s_q.pend && !rise) s_d.aligned = 1'b1;

        s_d.out = shaped;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ord_word    = s_q.out;
    assign ord_aligned = s_q.aligned;

    // nothing aligns while idle
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.armed && !s_q.pend && !rise && !ord_aligned) |=> !ord_aligned);

    // the flag only rises from a lane-0 match or the step after a pad
    assert_flag_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ord_aligned) |-> ($past(hit) || $past(s_q.pend)));

    // an upper-lane match holds the flag low for the pad word
    assert_pad_word_unflagged_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && idx != '0) |=> !ord_aligned);

    // at most one lane is chosen
    assert_one_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // aligned state is sticky until a new edge
    assert_hold_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ord_aligned && !rise) |=> (ord_aligned && $stable(s_q.shift)));

    // an edge without a match leaves a clean, unshifted search
    assert_edge_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !hit) |=> (!ord_aligned && s_q.shift == '0));

endmodule

// File: tb/test_byte_order_aligner.sv
module test_byte_order_aligner;

    localparam int NV = 19;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_manual = 1'b0;
    logic [7:0]  cfg_pattern = 8'hBC;
    logic [7:0]  cfg_pad = 8'hF7;
    logic        sync_status = 1'b0;
    logic        ord_enable = 1'b0;
    logic [15:0] in_word = '0;
    logic [15:0] ord_word;
    logic        ord_aligned;

    int checks = 0;
    int bad    = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    byte_order_aligner #(.NB(2), .BW(8)) i_byte_order_aligner (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_manual  (cfg_manual),
        .cfg_pattern (cfg_pattern),
        .cfg_pad     (cfg_pad),
        .sync_status (sync_status),
        .ord_enable  (ord_enable),
        .in_word     (in_word),
        .ord_word    (ord_word),
        .ord_aligned (ord_aligned)
    );

    // {sync, enable, input word, expected word, expected flag}; automatic mode
    localparam logic [34:0] VEC [NV] = '{
        {1'b0, 1'b0, 16'hBC11, 16'hBC11, 1'b0}, // R1 not armed
        {1'b1, 1'b0, 16'h2233, 16'h2233, 1'b0}, // R10 armed, no match
        {1'b1, 1'b0, 16'hBC44, 16'hF744, 1'b0}, // R5 lane 1 match, pad
        {1'b1, 1'b0, 16'h6655, 16'h55BC, 1'b1}, // R5 pattern in lane 0
        {1'b1, 1'b0, 16'h8877, 16'h7766, 1'b1}, // R6 carry
        {1'b1, 1'b0, 16'hBC99, 16'h9988, 1'b1}, // R8 later pattern ignored
        {1'b0, 1'b0, 16'h00AA, 16'hAABC, 1'b1}, // R8 falling edge ignored
        {1'b0, 1'b1, 16'h1234, 16'h3400, 1'b1}, // R2 enable ignored in auto
        {1'b1, 1'b0, 16'h56BC, 16'h56BC, 1'b1}, // R9 R4 edge + lane 0 match
        {1'b1, 1'b0, 16'hBCBC, 16'hBCBC, 1'b1}, // R8
        {1'b0, 1'b0, 16'h0102, 16'h0102, 1'b1}, // R8
        {1'b1, 1'b0, 16'h0102, 16'h0102, 1'b0}, // R9 clears flag
        {1'b1, 1'b0, 16'hBCBC, 16'hBCBC, 1'b1}, // R7 lowest lane wins
        {1'b1, 1'b0, 16'h0304, 16'h0304, 1'b1}, // R6 shift zero
        {1'b0, 1'b0, 16'h0506, 16'h0506, 1'b1}, // R8
        {1'b1, 1'b0, 16'hBC07, 16'hF707, 1'b0}, // R9 R5 edge + lane 1 match
        {1'b0, 1'b0, 16'h0908, 16'h08BC, 1'b1}, // R5 R6
        {1'b1, 1'b0, 16'hABCD, 16'hABCD, 1'b0}, // R9 shift cleared, carry dropped
        {1'b1, 1'b0, 16'hCDEF, 16'hCDEF, 1'b0}  // R10 searching, unshifted
    };
    localparam int VTAG [NV] = '{1, 10, 5, 5, 6, 8, 8, 2, 9, 8, 8, 9, 7, 6, 8, 9, 5, 9, 10};

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", checks, bad);
    endtask

    task automatic step(input logic s, input logic e, input logic [15:0] w,
                        input logic [15:0] xo, input logic xa, input string tag);
        sync_status = s;
        ord_enable  = e;
        in_word     = w;
        @(negedge clk);
        checks++;
        if (ord_word !== xo || ord_aligned !== xa) begin
            bad++;
            $display("FAIL %s: got word=%h aligned=%b, expected word=%h aligned=%b",
                     tag, ord_word, ord_aligned, xo, xa);
        end
    endtask

    task automatic do_reset(input logic manual);
        rst_n       = 1'b0;
        cfg_manual  = manual;
        sync_status = 1'b0;
        ord_enable  = 1'b0;
        in_word     = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        checks++;
        if (ord_word !== 16'h0000 || ord_aligned !== 1'b0) begin
            bad++;
            $display("FAIL R1: got word=%h aligned=%b after reset, expected word=0000 aligned=0",
                     ord_word, ord_aligned);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: got timeout, expected end of run");
            summary();
            $finish;
        end
    end

    initial begin
        do_reset(1'b0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][34], VEC[i][33], VEC[i][32:17], VEC[i][16:1], VEC[i][0],
                 $sformatf("R%0d vector %0d", VTAG[i], i));
        end

        // manual mode directed cases
        do_reset(1'b1);
        step(1'b1, 1'b0, 16'h11BC, 16'h11BC, 1'b0, "R3 sync ignored in manual");
        step(1'b1, 1'b1, 16'h11BC, 16'h11BC, 1'b1, "R3 R4 enable edge, lane 0");
        step(1'b1, 1'b1, 16'hBC22, 16'hBC22, 1'b1, "R8 held high, pattern ignored");
        step(1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1, "R8 falling enable");
        step(1'b0, 1'b1, 16'hBC33, 16'hF733, 1'b0, "R5 edge + lane 1 match");
        step(1'b0, 1'b0, 16'h4455, 16'h55BC, 1'b1, "R5 R6 pattern lane 0");
        step(1'b0, 1'b1, 16'h0001, 16'h0001, 1'b0, "R9 rearm clears");
        step(1'b0, 1'b0, 16'hBC02, 16'hF702, 1'b0, "R5 armed lane 1 match");
        step(1'b0, 1'b1, 16'h0304, 16'h0304, 1'b0, "R9 edge in pad cycle wins");
        step(1'b0, 1'b1, 16'h0506, 16'h0506, 1'b0, "R10 still searching");
        step(1'b0, 1'b1, 16'h07BC, 16'h07BC, 1'b1, "R4 lane 0 match");

        done = 1;
        summary();
        $finish;
    end

endmodule